// File: doc/BRIEF.md
# Program Level Priority Selector

The block keeps one ready flag for each of 64 program levels and picks the level a single processor should run next. A level becomes ready when an I/O transfer tied to it terminates (with or without error), when its external interrupt line pulses, or, for one fixed level, when the elapsed-time tick arrives. Software clears a level's ready flag when that level has no more work. Two further per-level vectors are written by program: a permit vector, where a cleared bit stops the level from interrupting, and an assignment mask, where a cleared bit hands the level to the other processor.

Level 0 is the most urgent. The eligible winner is the lowest-numbered level that is ready, permitted and assigned here. When the winner differs from the level now running, the block raises a switch request that carries the outgoing and incoming level numbers. A save/restore sequencer performs the context swap and returns an acknowledge, at which point the block records the new running level. The request, and the level it names, stay fixed until that acknowledge.

Top module: `lvl_prio_top`

## Requirements
- R1: After reset every ready flag is 0, every permit bit and every mask bit is 1, `idle` is 1, `swReq` is 0 and `curValid` is 0.
- R2: `ioDoneValid` high for one cycle sets the ready flag of level `ioDoneLevel`, whatever the transfer outcome.
- R3: `irqLines[i]` high for one cycle sets the ready flag of level i; `tickPulse` sets the ready flag of level `TIMER_LEVEL` (63 by default).
- R4: The winner is the lowest-numbered level whose ready, permit and mask bits are all 1. With no request pending and a winner that differs from the running level (or nothing running), `swReq` rises on the second rising edge after the setting event, with `swNewLevel` = winner, `swOldLevel`/`swOldValid` = the running level and its valid flag.
- R5: While `swReq` is high and `swAck` is low, `swReq` stays high and `swNewLevel` does not change, even if a more urgent level becomes ready.
- R6: At the edge where `swAck` is high with `swReq` high, `curLevel` takes `swNewLevel`, `curValid` becomes 1 and `swReq` falls.
- R7: With no eligible level and no request pending, `idle` is 1, no request is raised, and `curValid` is 0 from the next edge.
- R8: A set event and a software clear (`clrValid`/`clrLevel`) on the same level in the same cycle leave the ready flag set.
- R9: Writing the permit vector (`permitWrEn`) or the mask vector (`maskWrEn`) replaces it whole; a level whose bit is 0 in either is never chosen.
- R10: `clrValid` clears the ready flag of level `clrLevel`, so that level stops being chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ioDoneValid | input | 1 | I/O termination event strobe |
| ioDoneLevel | input | 6 | Level tied to the terminated transfer |
| irqLines | input | 64 | External interrupt pulses, one per level |
| tickPulse | input | 1 | Elapsed-time tick |
| clrValid | input | 1 | Software clear strobe |
| clrLevel | input | 6 | Level whose ready flag is cleared |
| permitWrEn | input | 1 | Load the permit vector |
| permitWrData | input | 64 | New permit vector |
| maskWrEn | input | 1 | Load the assignment mask |
| maskWrData | input | 64 | New assignment mask |
| swAck | input | 1 | Sequencer has completed the switch |
| swReq | output | 1 | Switch request |
| swNewLevel | output | 6 | Level to enter |
| swOldLevel | output | 6 | Level being left |
| swOldValid | output | 1 | A level was running when the request was made |
| curLevel | output | 6 | Running level |
| curValid | output | 1 | A level is running |
| idle | output | 1 | No eligible level and no request pending |

## Verification
A flag-setting or clearing event lands in the ready vector on the first edge and turns into a request on the second, so the bench drives each event on a falling edge, removes it, lets two rising edges pass and samples on the next falling edge. An acknowledge takes effect at the single edge it is held across, so the running level is compared one falling edge later. The bench keeps its own copy of the three vectors, updates it with the set-over-clear rule at the event edge, and derives the expected winner from that copy before each sample; the freeze case adds cycles while a request waits and checks that the named level is unchanged.

// File: rtl/lvl_pkg.sv
package lvl_pkg;
  // Strobes from the control FSM to the level datapath.
  typedef struct packed {
    logic latchReq;  // capture winner and running level into the request
    logic enter;     // make the requested level the running one
    logic goIdle;    // nothing eligible: drop the running level
  } lvlStrobe_t;
endpackage

// File: rtl/lvl_datapath.sv
module lvl_datapath
  import lvl_pkg::*;
#(
  parameter int NUM_LEVELS  = 64,
  parameter int TIMER_LEVEL = NUM_LEVELS - 1,
  localparam int LW = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ioDoneValid,
  input  logic [LW-1:0]         ioDoneLevel,
  input  logic [NUM_LEVELS-1:0] irqLines,
  input  logic                  tickPulse,
  input  logic                  clrValid,
  input  logic [LW-1:0]         clrLevel,
  input  logic                  permitWrEn,
  input  logic [NUM_LEVELS-1:0] permitWrData,
  input  logic                  maskWrEn,
  input  logic [NUM_LEVELS-1:0] maskWrData,
  input  lvlStrobe_t            strobe,
  output logic                  winValid,
  output logic                  winDiffers,
  output logic [LW-1:0]         curLevel,
  output logic                  curValid,
  output logic [LW-1:0]         reqNewLevel,
  output logic [LW-1:0]         reqOldLevel,
  output logic                  reqOldValid
);
  logic [NUM_LEVELS-1:0] actBits, permitBits, maskBits, eligible;
  logic [LW-1:0]         winLevel;

  // Per-level ready flag; a set in the same cycle as a clear wins.
  for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_lvl
    logic setHit, clrHit;
    assign setHit = (ioDoneValid && ioDoneLevel == LW'(i)) || irqLines[i] ||
                    (tickPulse && (i == TIMER_LEVEL));
    assign clrHit = clrValid && clrLevel == LW'(i);
    always_ff @(posedge clk) begin
      if (!rst_n)      actBits[i] <= 1'b0;
      else if (setHit) actBits[i] <= 1'b1;
      else if (clrHit) actBits[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      permitBits <= '1;
      maskBits   <= '1;
    end else begin
      if (permitWrEn) permitBits <= permitWrData;
      if (maskWrEn)   maskBits   <= maskWrData;
    end
  end

  assign eligible = actBits & permitBits & maskBits;

  // Lowest index wins: scan downward so the last hit is the smallest.
  always_comb begin
    winValid = 1'b0;
    winLevel = '0;
    for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        winValid = 1'b1;
        winLevel = LW'(i);
      end
    end
  end

  assign winDiffers = !curValid || (winLevel != curLevel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curLevel    <= '0;
      curValid    <= 1'b0;
      reqNewLevel <= '0;
      reqOldLevel <= '0;
      reqOldValid <= 1'b0;
    end else begin
      if (strobe.latchReq) begin
        reqNewLevel <= winLevel;
        reqOldLevel <= curLevel;
        reqOldValid <= curValid;
      end
      if (strobe.enter) begin
        curLevel <= reqNewLevel;
        curValid <= 1'b1;
      end else if (strobe.goIdle) begin
        curValid <= 1'b0;
      end
    end
  end

  // R8: a same-cycle set and clear on one level leaves it set.
  p_setwins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ioDoneValid && clrValid && ioDoneLevel == clrLevel) |=> actBits[$past(clrLevel)]);

  // R10: a lone clear with no set source removes the flag.
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clrValid && !ioDoneValid && !tickPulse && irqLines == '0) |=> !actBits[$past(clrLevel)]);
endmodule

// File: rtl/lvl_control.sv
module lvl_control
  import lvl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       winValid,
  input  logic       winDiffers,
  input  logic       swAck,
  output lvlStrobe_t strobe,
  output logic       swReq,
  output logic       idle
);
  always_comb begin
    strobe.latchReq = !swReq && winValid && winDiffers;
    strobe.enter    = swReq && swAck;
    strobe.goIdle   = !swReq && !winValid;
  end

  assign idle = !swReq && !winValid;

  always_ff @(posedge clk) begin
    if (!rst_n)               swReq <= 1'b0;
    else if (strobe.latchReq) swReq <= 1'b1;
    else if (strobe.enter)    swReq <= 1'b0;
  end

  // R7: idle never coexists with a pending request.
  p_idle_noreq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> !$rose(swReq));
endmodule

// File: rtl/lvl_prio_top.sv
module lvl_prio_top
  import lvl_pkg::*;
#(
  parameter int NUM_LEVELS  = 64,
  parameter int TIMER_LEVEL = NUM_LEVELS - 1,
  localparam int LW = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ioDoneValid,
  input  logic [LW-1:0]         ioDoneLevel,
  input  logic [NUM_LEVELS-1:0] irqLines,
  input  logic                  tickPulse,
  input  logic                  clrValid,
  input  logic [LW-1:0]         clrLevel,
  input  logic                  permitWrEn,
  input  logic [NUM_LEVELS-1:0] permitWrData,
  input  logic                  maskWrEn,
  input  logic [NUM_LEVELS-1:0] maskWrData,
  input  logic                  swAck,
  output logic                  swReq,
  output logic [LW-1:0]         swNewLevel,
  output logic [LW-1:0]         swOldLevel,
  output logic                  swOldValid,
  output logic [LW-1:0]         curLevel,
  output logic                  curValid,
  output logic                  idle
);
  lvlStrobe_t strobe;
  logic       winValid, winDiffers;

  lvl_datapath #(.NUM_LEVELS(NUM_LEVELS), .TIMER_LEVEL(TIMER_LEVEL)) u_dp (
    .clk, .rst_n, .ioDoneValid, .ioDoneLevel, .irqLines, .tickPulse,
    .clrValid, .clrLevel, .permitWrEn, .permitWrData, .maskWrEn, .maskWrData,
    .strobe, .winValid, .winDiffers, .curLevel, .curValid,
    .reqNewLevel(swNewLevel), .reqOldLevel(swOldLevel), .reqOldValid(swOldValid)
  );

  lvl_control u_ctl (
    .clk, .rst_n, .winValid, .winDiffers, .swAck, .strobe, .swReq, .idle
  );

  // R5: a pending request and its target stay put until acknowledged.
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (swReq && !swAck) |=> (swReq && $stable(swNewLevel)));

  // R6: acknowledge makes the requested level the running one.
  p_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (swReq && swAck) |=> (!swReq && curValid && curLevel == $past(swNewLevel)));

  // R4: a new request never targets the level already running.
  p_differs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(swReq) |-> (!swOldValid || swNewLevel != swOldLevel));
endmodule

// File: tb/lvl_prio_top_test.sv
module lvl_prio_top_test;
  localparam int N = 64;
  localparam int TL = 63;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ioDoneValid = 0, tickPulse = 0, clrValid = 0;
  logic permitWrEn = 0, maskWrEn = 0, swAck = 0;
  logic [5:0] ioDoneLevel = 0, clrLevel = 0;
  logic [N-1:0] irqLines = '0, permitWrData = '1, maskWrData = '1;
  logic swReq, swOldValid, curValid, idle;
  logic [5:0] swNewLevel, swOldLevel, curLevel;

  lvl_prio_top uut (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [N-1:0] mAct = '0, mPermit = '1, mMask = '1;
  int mCur = 0;
  bit mCurValid = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expWin();
    for (int i = 0; i < N; i++)
      if (mAct[i] && mPermit[i] && mMask[i]) return i;
    return -1;
  endfunction

  // Apply the driven ops to the model (set beats clear).
  function automatic void modelEdge();
    for (int i = 0; i < N; i++) begin
      bit s, c;
      s = (ioDoneValid && ioDoneLevel == i) || irqLines[i] || (tickPulse && i == TL);
      c = clrValid && clrLevel == i;
      if (s) mAct[i] = 1'b1;
      else if (c) mAct[i] = 1'b0;
    end
    if (permitWrEn) mPermit = permitWrData;
    if (maskWrEn) mMask = maskWrData;
  endfunction

  task automatic clearOps();
    ioDoneValid = 0; tickPulse = 0; clrValid = 0; irqLines = '0;
    permitWrEn = 0; maskWrEn = 0;
  endtask

  // Ops are already driven (at a falling edge). Run one event, then check.
  task automatic settle(string tag);
    int w;
    @(posedge clk); modelEdge();
    @(negedge clk); clearOps();
    @(posedge clk);
    @(negedge clk);
    w = expWin();
    if (w < 0) begin
      check(swReq == 0, {tag, " R7 swReq"}, swReq, 0);
      check(idle == 1, {tag, " R7 idle"}, idle, 1);
      @(posedge clk); @(negedge clk);
      check(curValid == 0, {tag, " R7 curValid"}, curValid, 0);
      mCurValid = 0;
    end else if (!mCurValid || w != mCur) begin
      check(swReq == 1, {tag, " R4 swReq"}, swReq, 1);
      check(swNewLevel == w, {tag, " R4 new"}, swNewLevel, w);
      check(swOldValid == mCurValid, {tag, " R4 oldValid"}, swOldValid, mCurValid);
      if (mCurValid) check(swOldLevel == mCur, {tag, " R4 old"}, swOldLevel, mCur);
      swAck = 1;
      @(posedge clk); @(negedge clk);
      swAck = 0;
      check(curLevel == w && curValid, {tag, " R6 cur"}, curLevel, w);
      check(swReq == 0, {tag, " R6 drop"}, swReq, 0);
      mCur = w; mCurValid = 1;
    end else begin
      check(swReq == 0, {tag, " R4 no-switch"}, swReq, 0);
      check(curLevel == mCur, {tag, " R4 stay"}, curLevel, mCur);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(idle == 1, "R1 idle", idle, 1);
    check(swReq == 0, "R1 swReq", swReq, 0);
    check(curValid == 0, "R1 curValid", curValid, 0);

    // R2 I/O termination on level 10
    ioDoneValid = 1; ioDoneLevel = 6'd10; settle("R2 io");

    // R5 freeze: level 3 arrives, then level 1 while pending
    irqLines = 64'd1 << 3;
    @(posedge clk); modelEdge(); @(negedge clk); clearOps();
    @(posedge clk); @(negedge clk);
    check(swReq == 1 && swNewLevel == 3, "R5 first", swNewLevel, 3);
    check(swOldLevel == 10, "R4 old level", swOldLevel, 10);
    irqLines = 64'd1 << 1;
    @(posedge clk); modelEdge(); @(negedge clk); clearOps();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(swReq == 1, "R5 held", swReq, 1);
    check(swNewLevel == 3, "R5 frozen", swNewLevel, 3);
    swAck = 1; @(posedge clk); @(negedge clk); swAck = 0;
    check(curLevel == 3, "R6 enter", curLevel, 3);
    mCur = 3; mCurValid = 1;
    settle("R5 next");   // now level 1 wins

    // R8 same-cycle set and clear on level 1 (running): stays
    ioDoneValid = 1; ioDoneLevel = 6'd1; clrValid = 1; clrLevel = 6'd1;
    settle("R8");
    check(curLevel == 1, "R8 kept", curLevel, 1);

    // R9 permit bit 1 cleared -> level 3 wins; mask bit 3 cleared -> 10
    permitWrEn = 1; permitWrData = ~(64'd1 << 1); settle("R9 permit");
    check(curLevel == 3, "R9 permit", curLevel, 3);
    maskWrEn = 1; maskWrData = ~(64'd1 << 3); settle("R9 mask");
    check(curLevel == 10, "R9 mask", curLevel, 10);
    permitWrEn = 1; permitWrData = '1; maskWrEn = 1; maskWrData = '1;
    settle("R9 restore");

    // R10 clear levels 1,3,10; R3 tick sets level 63
    clrValid = 1; clrLevel = 6'd1; settle("R10 c1");
    clrValid = 1; clrLevel = 6'd3; settle("R10 c3");
    tickPulse = 1; settle("R3 tick");
    clrValid = 1; clrLevel = 6'd10; settle("R10 c10");
    check(curLevel == TL, "R3 timer level", curLevel, TL);
    clrValid = 1; clrLevel = 6'(TL); settle("R7 empty");
    check(idle == 1, "R7 idle end", idle, 1);

    // Random mix
    for (int it = 0; it < 400; it++) begin
      if ($urandom % 3 == 0) begin ioDoneValid = 1; ioDoneLevel = 6'($urandom); end
      if ($urandom % 4 == 0) irqLines = 64'd1 << ($urandom % N);
      if ($urandom % 10 == 0) tickPulse = 1;
      if ($urandom % 2 == 0) begin
        clrValid = 1;
        clrLevel = ($urandom % 3 != 0 && mCurValid) ? 6'(mCur) : 6'($urandom);
      end
      if ($urandom % 15 == 0) begin
        permitWrEn = 1; permitWrData = ~(64'd1 << ($urandom % N));
      end
      if ($urandom % 15 == 0) begin
        maskWrEn = 1; maskWrData = ~({32'd0, $urandom} & {32'd0, $urandom});
      end
      settle("rand");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule